// File: doc/BRIEF.md
# Engine Enable and Access Gating Controller

This block holds the master enable word of a graphics controller and sits between a single 32-bit register bus and five sub-engines: a command FIFO engine, a timer, a framebuffer controller, a display CRTC and a video overlay. It decodes each bus access. An access to the enable word is served locally. An access that falls inside one engine's address window is forwarded to that engine, but only while that engine is switched on. While an engine is switched off, reads of its window come back as zero and writes to it never reach it.

Every write to the enable word is also a reset command. Each engine whose bit is zero in the written data gets a one-cycle reset pulse. A zero in the timer or CRTC position also raises a one-cycle strobe that asks the interrupt controller to recompute its summary. The gating mask that guards the five windows is reloaded only when the written data changes one of the five defined bits. Bits outside those positions are kept as plain storage.

Top module: `engine_enable_gate`

## Requirements
- R1: After reset the enable word reads 0x01110000, `engEnable` is 5'b01110, and `engRst`, `irqReeval` and `rspValid` are low.
- R2: The enable word is at byte offset 0x200. A read of that offset returns all 32 stored bits exactly as last written. Access to the word is never gated, even when every engine is off.
- R3: `engEnable` index 0..4 (FIFO, timer, framebuffer, CRTC, video) follows enable-word bits 8, 16, 20, 24 and 28 respectively, from the cycle after the write.
- R4: Every write to the enable word pulses `engRst[i]` high for exactly the one cycle after the accepting edge, for each engine whose bit is 0 in the written data. This holds even if that bit was already 0.
- R5: While an engine is disabled, a read inside its window returns data 0 and does not assert its `engRdEn`.
- R6: While an engine is disabled, a write inside its window does not assert its `engWrEn`.
- R7: While an engine is enabled, accesses inside its window assert its `engRdEn` or `engWrEn` in the same cycle, and a read returns that engine's `engRdData` slice. Windows: FIFO 0x2000–0x3FFF, video 0x8000–0x8FFF, timer 0x9000–0x9FFF, framebuffer 0x100000–0x100FFF, CRTC 0x600000–0x600FFF.
- R8: `irqReeval` pulses for one cycle after an enable-word write whose data has bit 16 or bit 24 at 0. A write that clears only bit 8 and/or bit 28 does not raise it.
- R9: A new enable value governs the bus access in the very next cycle after the enable write.
- R10: Enable-word bits other than 8, 16, 20, 24 and 28 have no effect on gating or resets. A read of an address that is neither the enable word nor any window returns 0.
- R11: Every read gets `rspValid` high for exactly one cycle, in the cycle after the request, with `rspData` valid. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request valid this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read response valid |
| rspData | output | 32 | Read response data |
| engEnable | output | 5 | Per-engine enable level |
| engRst | output | 5 | Per-engine one-cycle reset pulse |
| irqReeval | output | 1 | One-cycle request to recompute the interrupt summary |
| engRdEn | output | 5 | Per-engine read strobe (gated) |
| engWrEn | output | 5 | Per-engine write strobe (gated) |
| engAddr | output | ADDR_W | Address forwarded to engines |
| engWdata | output | 32 | Write data forwarded to engines |
| engRdData | input | 160 | Read data of the five engines, engine i at bits 32*i+31..32*i |

## Verification
Two functions can fall in the same cycle. One is the reset pulse that an enable write issues to an engine. The other is the gating decision for the bus access that immediately follows that write. The bench issues an enable write that switches an engine off and, with no idle cycle in between, an access to that engine's window. In one cycle it then judges three things: the reset pulse is high, the engine's strobe stays low, and the read response that follows is zero. It then repeats the pair with the engine switched back on, where the forwarded strobe and the engine data must appear.

// File: rtl/engine_enable_gate_pkg.sv
package engine_enable_gate_pkg;

  localparam int NUM_ENG = 5;
  localparam int DATA_W  = 32;

  // engine order: 0 FIFO, 1 timer, 2 framebuffer, 3 CRTC, 4 video overlay
  localparam int ENG_BIT [NUM_ENG] = '{8, 16, 20, 24, 28};

  localparam logic [31:0] WIN_BASE [NUM_ENG] =
    '{32'h0000_2000, 32'h0000_9000, 32'h0010_0000, 32'h0060_0000, 32'h0000_8000};
  localparam int WIN_LOG2 [NUM_ENG] = '{13, 12, 12, 12, 12};

  localparam logic [31:0] EN_REG_OFF  = 32'h0000_0200;
  localparam logic [31:0] EN_RESET    = 32'h0111_0000;
  // engines whose shutdown asks for an interrupt recompute (timer, CRTC)
  localparam logic [NUM_ENG-1:0] IRQ_ENG_MASK = 5'b01010;

  typedef struct packed {
    logic               enWr;
    logic               enRd;
    logic               rdAny;
    logic [NUM_ENG-1:0] winHit;
    logic [NUM_ENG-1:0] winRd;
    logic [NUM_ENG-1:0] winWr;
  } ctrl_strobe_t;

endpackage

// File: rtl/engine_enable_gate_ctrl.sv
module engine_enable_gate_ctrl
  import engine_enable_gate_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [NUM_ENG-1:0] gateMask,
  output ctrl_strobe_t       strobes
);

  logic               enHit;
  logic [NUM_ENG-1:0] winHit;
  logic               rdReq;
  logic               wrReq;

  assign enHit = (reqAddr == EN_REG_OFF[ADDR_W-1:0]);
  assign rdReq = reqValid && !reqWrite;
  assign wrReq = reqValid && reqWrite;

  for (genvar i = 0; i < NUM_ENG; i++) begin : g_win
    localparam int LO = WIN_LOG2[i];
    assign winHit[i] = (reqAddr[ADDR_W-1:LO] == WIN_BASE[i][ADDR_W-1:LO]);
  end

  always_comb begin
    strobes        = '0;
    strobes.enWr   = wrReq && enHit;
    strobes.enRd   = rdReq && enHit;
    strobes.rdAny  = rdReq;
    strobes.winHit = winHit;
    strobes.winRd  = (rdReq ? winHit : '0) & gateMask;
    strobes.winWr  = (wrReq ? winHit : '0) & gateMask;
  end

  // windows never overlap each other
  p_single_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.winHit));

  // a switched-off engine never sees a write strobe
  p_write_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.winWr & ~gateMask) == '0);

  // a switched-off engine never sees a read strobe
  p_read_blocked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.winRd & ~gateMask) == '0);

endmodule

// File: rtl/engine_enable_gate_dp.sv
module engine_enable_gate_dp
  import engine_enable_gate_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strobes,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [NUM_ENG*DATA_W-1:0] engRdData,
  output logic [NUM_ENG-1:0]        gateMask,
  output logic [NUM_ENG-1:0]        engRst,
  output logic                      irqReeval,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData
);

  logic [DATA_W-1:0]  enReg;
  logic [NUM_ENG-1:0] wdBits;
  logic [NUM_ENG-1:0] curBits;
  logic [DATA_W-1:0]  winData;

  for (genvar i = 0; i < NUM_ENG; i++) begin : g_bits
    assign wdBits[i]  = reqWdata[ENG_BIT[i]];
    assign curBits[i] = enReg[ENG_BIT[i]];
  end

  always_comb begin
    winData = '0;
    for (int i = 0; i < NUM_ENG; i++) begin
      if (strobes.winRd[i]) winData = winData | engRdData[i*DATA_W +: DATA_W];
    end
  end

  // enable word, reset pulses and interrupt recompute strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= EN_RESET;
      engRst    <= '0;
      irqReeval <= 1'b0;
    end else if (strobes.enWr) begin
      enReg     <= reqWdata;
      engRst    <= ~wdBits;
      irqReeval <= |(~wdBits & IRQ_ENG_MASK);
    end else begin
      engRst    <= '0;
      irqReeval <= 1'b0;
    end
  end

  // gating mask: reloaded only when a defined bit actually changes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENG; i++) gateMask[i] <= EN_RESET[ENG_BIT[i]];
    end else if (strobes.enWr && (wdBits != curBits)) begin
      gateMask <= wdBits;
    end
  end

  // read response path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobes.rdAny;
      if (strobes.rdAny) rspData <= strobes.enRd ? enReg : winData;
    end
  end

  p_rst_needs_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|engRst) |-> $past(strobes.enWr));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqReeval |-> $past(strobes.enWr && (!reqWdata[16] || !reqWdata[24])));

  p_gate_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.enWr) |-> $stable(gateMask));

  p_gate_track_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.enWr) && $past(rstN)) |-> (gateMask == $past(wdBits)));

  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(strobes.rdAny));

endmodule

// File: rtl/engine_enable_gate.sv
module engine_enable_gate
  import engine_enable_gate_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [31:0]               reqWdata,
  output logic                      rspValid,
  output logic [31:0]               rspData,
  output logic [4:0]                engEnable,
  output logic [4:0]                engRst,
  output logic                      irqReeval,
  output logic [4:0]                engRdEn,
  output logic [4:0]                engWrEn,
  output logic [ADDR_W-1:0]         engAddr,
  output logic [31:0]               engWdata,
  input  logic [159:0]              engRdData
);

  ctrl_strobe_t       strobes;
  logic [NUM_ENG-1:0] gateMask;

  engine_enable_gate_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .gateMask (gateMask),
    .strobes  (strobes)
  );

  engine_enable_gate_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqWdata  (reqWdata),
    .engRdData (engRdData),
    .gateMask  (gateMask),
    .engRst    (engRst),
    .irqReeval (irqReeval),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

  assign engEnable = gateMask;
  assign engRdEn   = strobes.winRd;
  assign engWrEn   = strobes.winWr;
  assign engAddr   = reqAddr;
  assign engWdata  = reqWdata;

endmodule

// File: tb/engine_enable_gate_tb.sv
module engine_enable_gate_tb;

  logic         clk = 1'b0;
  logic         rstN;
  logic         reqValid, reqWrite;
  logic [23:0]  reqAddr;
  logic [31:0]  reqWdata;
  logic         rspValid;
  logic [31:0]  rspData;
  logic [4:0]   engEnable, engRst, engRdEn, engWrEn;
  logic         irqReeval;
  logic [23:0]  engAddr;
  logic [31:0]  engWdata;
  logic [159:0] engRdData;

  int checks = 0;
  int errors = 0;

  logic [31:0] model;
  logic [4:0]  expRst;
  logic        expIrq;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  engine_enable_gate u_dut (.*);

  function automatic logic [31:0] engData(int i, logic [23:0] a);
    return {4'hA, i[3:0], 8'h00, a[15:0]};
  endfunction

  always_comb begin
    for (int i = 0; i < 5; i++) engRdData[i*32 +: 32] = engData(i, reqAddr);
  end

  function automatic int winIdx(logic [23:0] a);
    if (a >= 24'h2000   && a <= 24'h3FFF)   return 0;
    if (a >= 24'h9000   && a <= 24'h9FFF)   return 1;
    if (a >= 24'h100000 && a <= 24'h100FFF) return 2;
    if (a >= 24'h600000 && a <= 24'h600FFF) return 3;
    if (a >= 24'h8000   && a <= 24'h8FFF)   return 4;
    return -1;
  endfunction

  function automatic logic [4:0] bitsOf(logic [31:0] v);
    return {v[28], v[24], v[20], v[16], v[8]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    expRst = '0; expIrq = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [23:0] a, input logic [31:0] d, input string req);
    int idx;
    logic [4:0] hitV, expRd, expWr;
    @(negedge clk);
    check(engEnable == bitsOf(model), "R3", {27'd0, engEnable}, {27'd0, bitsOf(model)});
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    idx  = winIdx(a);
    hitV = (idx >= 0) ? (5'b1 << idx) : 5'b0;
    expRd = wr ? 5'b0 : (hitV & bitsOf(model));
    expWr = wr ? (hitV & bitsOf(model)) : 5'b0;
    #1;
    check(engRdEn == expRd, req, {27'd0, engRdEn}, {27'd0, expRd});
    check(engWrEn == expWr, req, {27'd0, engWrEn}, {27'd0, expWr});
    if (!wr) begin
      if (a == 24'h200)               expQ.push_back(model);
      else if (idx >= 0 && model[8 + 0] === model[8] && bitsOf(model)[idx])
                                      expQ.push_back(engData(idx, a));
      else                            expQ.push_back(32'h0);
      tagQ.push_back(req);
    end
    if (wr && a == 24'h200) begin
      expRst = ~bitsOf(d);
      expIrq = ~d[16] | ~d[24];
      model  = d;
    end else begin
      expRst = '0; expIrq = 1'b0;
    end
  endtask

  // monitor: compares pulses and read responses after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        check(engRst == expRst, "R4", {27'd0, engRst}, {27'd0, expRst});
        check(irqReeval == expIrq, "R8", {31'd0, irqReeval}, {31'd0, expIrq});
        if (rspValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R11", 32'd1, 32'd0);
          end else begin
            logic [31:0] e;
            string t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            check(rspData == e, t, rspData, e);
          end
        end
      end
    end
  end

  initial begin
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    expRst = '0; expIrq = 1'b0; model = 32'h0111_0000;
    rstN = 1'b0;
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(engEnable == 5'b01110, "R1", {27'd0, engEnable}, 32'h0E);
        check(engRst == 5'b0 && !irqReeval && !rspValid, "R1",
              {26'd0, engRst, irqReeval}, 32'h0);
        access(0, 24'h000200, 0, "R1");
        // enabled timer, disabled FIFO and video
        access(0, 24'h009010, 0, "R7");
        access(0, 24'h002040, 0, "R5");
        access(0, 24'h008004, 0, "R5");
        access(1, 24'h002040, 32'h55, "R6");
        access(1, 24'h600100, 32'h66, "R7");
        idle();
        // switch everything on, undefined bits too
        access(1, 24'h000200, 32'hFFFF_FFFF, "R2");
        access(0, 24'h000200, 0, "R2");
        access(0, 24'h002ABC, 0, "R7");
        access(0, 24'h100FFC, 0, "R7");
        access(0, 24'h008FF0, 0, "R7");
        // FIFO off then back-to-back access (R9), no irq (R8)
        access(1, 24'h000200, 32'hFFFF_FEFF, "R4");
        access(0, 24'h003000, 0, "R9");
        access(1, 24'h002000, 32'h1, "R9");
        // repeated write with bit already 0 still resets (R4)
        access(1, 24'h000200, 32'hFFFF_FEFF, "R4");
        idle();
        // video off only: no irq; timer off: irq
        access(1, 24'h000200, 32'hEFFF_FEFF, "R8");
        access(1, 24'h000200, 32'hEFFE_FEFF, "R8");
        access(0, 24'h009000, 0, "R9");
        // only undefined bits change (R10)
        access(1, 24'h000200, 32'h0FFE_0EFF, "R10");
        access(0, 24'h100010, 0, "R10");
        access(0, 24'h000200, 0, "R10");
        access(0, 24'h000400, 0, "R10");
        access(0, 24'h7F0000, 0, "R10");
        // all off: register still accessible (R2)
        access(1, 24'h000200, 32'h0000_0000, "R4");
        access(0, 24'h600200, 0, "R5");
        access(1, 24'h100000, 32'h7, "R6");
        access(0, 24'h000200, 0, "R2");
        // CRTC back on, immediate access sees it (R9)
        access(1, 24'h000200, 32'h0100_0000, "R8");
        access(0, 24'h600204, 0, "R9");
        access(0, 24'h000200, 0, "R2");
        idle();
        idle();
        idle();
        check(expQ.size() == 0, "R11", expQ.size(), 32'd0);
      end
      begin
        #800000;
        check(1'b0, "watchdog", 32'd1, 32'd0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule